// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental encoder, plus its once-per-turn index signal, into count pulses and a direction bit, and integrates them in an up/down position counter. Inputs are expected to be already synchronised to `clk_i`. A three-bit mode field selects one of two counting resolutions and one of two counter styles. In bounded modes the count wraps at a programmable maximum. In index modes the count runs through the full 16-bit range and may be cleared by a qualified index pulse.

In index modes the block also watches for a count that should never occur. Counting up into maximum-plus-one, or counting down into all-ones, sets a sticky error flag. It also raises an error interrupt pulse unless that interrupt is masked. An index interrupt pulse marks every rising edge of the index input while the block is enabled.

Top module: `qenc_pos_top`

## Requirements
- R1: Phase A leading phase B (A,B sequence 00,10,11,01) is forward: `dir_o` becomes 1 and the count rises by one per count pulse. The opposite sequence is reverse: `dir_o` becomes 0 and the count falls by one.
- R2: With `mode_i[1]`=1 (4x), every change of either phase is one count pulse. The count and `dir_o` take their new values on the first rising clock edge that samples the changed input. With no pulse and no clear, the count holds.
- R3: With `mode_i[1]`=0 (2x), only changes of phase A count. A change of phase B alone leaves the count unchanged.
- R4: In bounded modes (`mode_i` = 3'b101 or 3'b111), counting up from `max_cnt_i` gives 0, and counting down from 0 gives `max_cnt_i`.
- R5: In index modes (`mode_i` = 3'b100 or 3'b110), the count wraps naturally over 16 bits. A pulse that makes the count equal `max_cnt_i`+1 while counting up, or 16'hFFFF while counting down, sets `err_flag_o`. On that same edge it also raises `err_irq_o` for exactly one cycle.
- R6: With `err_irq_dis_i`=1, an error still sets `err_flag_o`, but `err_irq_o` stays 0.
- R7: `err_flag_o` stays set while counting continues, until a cycle with `err_clr_i`=1 clears it. A new error in that same cycle wins over the clear. The up-wrap from 16'hFFFF to 0 raises no interrupt.
- R8: `idx_irq_o` pulses for one cycle after each rising edge of `idx_i`, in any enabled mode (`mode_i[2]`=1).
- R9: In index modes with `pos_res_i`=1, a qualified index rising edge clears the count to 0, and this takes priority over a count pulse in the same cycle. With `pos_res_i`=0 the count is not cleared.
- R10: Index qualification uses the current phase levels. In 4x mode, `idx_match_i[1]` is the required B level and `idx_match_i[0]` the required A level. In 2x mode, `idx_match_i[1]` selects the phase (0 = A, 1 = B) and `idx_match_i[0]` is its required level.
- R11: With `mode_i[2]`=0 the block is off: the count holds, and no index interrupt is raised.
- R12: During reset, `cnt_o`, `dir_o`, `err_flag_o`, `err_irq_o` and `idx_irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pha_i | input | 1 | Phase A, synchronised |
| phb_i | input | 1 | Phase B, synchronised |
| idx_i | input | 1 | Index, synchronised |
| mode_i | input | 3 | [2] enable, [1] 4x resolution, [0] bounded (1) or index (0) |
| max_cnt_i | input | CNT_W | Maximum count |
| pos_res_i | input | 1 | Allow clear on qualified index |
| idx_match_i | input | 2 | Index phase match value |
| err_irq_dis_i | input | 1 | Mask the error interrupt |
| err_clr_i | input | 1 | Clear the error flag |
| cnt_o | output | CNT_W | Position count |
| dir_o | output | 1 | Last count direction, 1 = forward |
| err_flag_o | output | 1 | Sticky count error flag |
| err_irq_o | output | 1 | Error interrupt pulse |
| idx_irq_o | output | 1 | Index interrupt pulse |

## Verification
Every result of the block is registered exactly once behind the input that causes it. A phase step, an index edge or a clear request driven before a rising edge therefore shows up in the count, direction, flag and both pulses on that very edge. The bench changes inputs on the falling edge and samples on the next falling edge, so each check lands one full cycle after its stimulus. Pulse outputs are sampled again one cycle later to confirm they lasted only a single cycle.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int unsigned QENC_CNT_W = 16;

  typedef enum logic [2:0] {
    QM_OFF    = 3'b000,
    QM_IDX_X2 = 3'b100,
    QM_MAX_X2 = 3'b101,
    QM_IDX_X4 = 3'b110,
    QM_MAX_X4 = 3'b111
  } qenc_mode_e;

  function automatic logic mode_en(input logic [2:0] m);
    return m[2];
  endfunction

  function automatic logic mode_x4(input logic [2:0] m);
    return m[1];
  endfunction

  function automatic logic mode_idx(input logic [2:0] m);
    return m[2] & ~m[0];
  endfunction
endpackage

// File: rtl/qenc_edge_dec.sv
module qenc_edge_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pha_i,
  input  logic phb_i,
  input  logic idx_i,
  input  logic en_i,
  input  logic x4_i,
  output logic pulse_o,
  output logic up_o,
  output logic idx_rise_o
);
  logic pha_q, phb_q, idx_q;

  // history tracks even while disabled so enabling gives no false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pha_q <= 1'b0;
      phb_q <= 1'b0;
      idx_q <= 1'b0;
    end else begin
      pha_q <= pha_i;
      phb_q <= phb_i;
      idx_q <= idx_i;
    end
  end

  logic a_edge, b_edge;
  assign a_edge     = pha_i ^ pha_q;
  assign b_edge     = phb_i ^ phb_q;
  assign pulse_o    = en_i & (x4_i ? (a_edge | b_edge) : a_edge);
  assign up_o       = pha_i ^ phb_q;
  assign idx_rise_o = en_i & idx_i & ~idx_q;
endmodule

// File: rtl/qenc_idx_qual.sv
module qenc_idx_qual (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pha_i,
  input  logic       phb_i,
  input  logic       idx_rise_i,
  input  logic       x4_i,
  input  logic       idx_mode_i,
  input  logic       pos_res_i,
  input  logic [1:0] match_i,
  output logic       clr_o,
  output logic       idx_irq_o
);
  logic match_ok, sel_lvl;

  assign sel_lvl  = match_i[1] ? phb_i : pha_i;
  assign match_ok = x4_i ? ((pha_i == match_i[0]) && (phb_i == match_i[1]))
                         : (sel_lvl == match_i[0]);
  assign clr_o    = idx_rise_i & idx_mode_i & pos_res_i & match_ok;

  logic idx_irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_irq_q <= 1'b0;
    else         idx_irq_q <= idx_rise_i;
  end
  assign idx_irq_o = idx_irq_q;

  AST_IDX_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_irq_q |=> !idx_irq_q); // R8
endmodule

// File: rtl/qenc_pos_cnt.sv
module qenc_pos_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             up_i,
  input  logic             clr_i,
  input  logic             idx_mode_i,
  input  logic [CNT_W-1:0] max_cnt_i,
  input  logic             err_irq_dis_i,
  input  logic             err_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             err_flag_o,
  output logic             err_irq_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_nx, max_p1;
  logic             dir_q, err_q, err_irq_q, err_hit;

  assign max_p1 = max_cnt_i + ONE;

  always_comb begin
    if (idx_mode_i)
      cnt_nx = up_i ? cnt_q + ONE : cnt_q - ONE;
    else if (up_i)
      cnt_nx = (cnt_q == max_cnt_i) ? '0 : cnt_q + ONE;
    else
      cnt_nx = (cnt_q == '0) ? max_cnt_i : cnt_q - ONE;
  end

  assign err_hit = idx_mode_i & pulse_i & ~clr_i &
                   (up_i ? (cnt_nx == max_p1) : (cnt_nx == ALL_ONES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      dir_q     <= 1'b0;
      err_q     <= 1'b0;
      err_irq_q <= 1'b0;
    end else begin
      if (clr_i)        cnt_q <= '0;
      else if (pulse_i) cnt_q <= cnt_nx;
      if (pulse_i)      dir_q <= up_i;
      // new error wins over software clear
      if (err_hit)        err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
      err_irq_q <= err_hit & ~err_irq_dis_i;
    end
  end

  assign cnt_o      = cnt_q;
  assign dir_o      = dir_q;
  assign err_flag_o = err_q;
  assign err_irq_o  = err_irq_q;

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_i && !clr_i) |=> $stable(cnt_q)); // R2
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !err_clr_i) |=> err_q); // R7
  AST_IRQ_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_q |-> err_q); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_q |-> !$past(err_irq_dis_i)); // R6
endmodule

// File: rtl/qenc_pos_top.sv
module qenc_pos_top
  import qenc_pkg::*;
#(
  parameter int unsigned CNT_W = QENC_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pha_i,
  input  logic             phb_i,
  input  logic             idx_i,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] max_cnt_i,
  input  logic             pos_res_i,
  input  logic [1:0]       idx_match_i,
  input  logic             err_irq_dis_i,
  input  logic             err_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             err_flag_o,
  output logic             err_irq_o,
  output logic             idx_irq_o
);
  logic en, x4, idx_mode;
  logic pulse, up, idx_rise, clr;

  assign en       = mode_en(mode_i);
  assign x4       = mode_x4(mode_i);
  assign idx_mode = mode_idx(mode_i);

  qenc_edge_dec u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pha_i      (pha_i),
    .phb_i      (phb_i),
    .idx_i      (idx_i),
    .en_i       (en),
    .x4_i       (x4),
    .pulse_o    (pulse),
    .up_o       (up),
    .idx_rise_o (idx_rise)
  );

  qenc_idx_qual u_idx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pha_i      (pha_i),
    .phb_i      (phb_i),
    .idx_rise_i (idx_rise),
    .x4_i       (x4),
    .idx_mode_i (idx_mode),
    .pos_res_i  (pos_res_i),
    .match_i    (idx_match_i),
    .clr_o      (clr),
    .idx_irq_o  (idx_irq_o)
  );

  qenc_pos_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pulse_i       (pulse),
    .up_i          (up),
    .clr_i         (clr),
    .idx_mode_i    (idx_mode),
    .max_cnt_i     (max_cnt_i),
    .err_irq_dis_i (err_irq_dis_i),
    .err_clr_i     (err_clr_i),
    .cnt_o         (cnt_o),
    .dir_o         (dir_o),
    .err_flag_o    (err_flag_o),
    .err_irq_o     (err_irq_o)
  );

  AST_OFF_NO_IDX_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !idx_irq_o); // R11
endmodule

// File: tb/qenc_pos_top_tb_top.sv
module qenc_pos_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pha = 1'b0, phb = 1'b0, idx = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic [15:0] max_cnt = 16'd100;
  logic        pos_res = 1'b0;
  logic [1:0]  match = 2'b00;
  logic        irq_dis = 1'b0, err_clr = 1'b0;
  logic [15:0] cnt;
  logic        dir, err_flag, err_irq, idx_irq;

  int n_chk = 0, n_fail = 0;
  int q = 0;

  always #2 clk = ~clk;

  qenc_pos_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pha_i(pha), .phb_i(phb), .idx_i(idx),
    .mode_i(mode), .max_cnt_i(max_cnt), .pos_res_i(pos_res),
    .idx_match_i(match), .err_irq_dis_i(irq_dis), .err_clr_i(err_clr),
    .cnt_o(cnt), .dir_o(dir), .err_flag_o(err_flag), .err_irq_o(err_irq),
    .idx_irq_o(idx_irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // phase state q: 0=00 1=10 2=11 3=01 (A,B); forward increments q
  task automatic drive_ph(input bit fwd);
    q = fwd ? (q + 1) % 4 : (q + 3) % 4;
    pha = (q == 1) || (q == 2);
    phb = (q == 2) || (q == 3);
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk("R12", "cnt", cnt, 0);
    chk("R12", "dir", dir, 0);
    chk("R12", "flags", {err_flag, err_irq, idx_irq}, 0);
  endtask

  task automatic t_fwd_rev_x4();
    mode = 3'b111; max_cnt = 16'd100; cyc();
    for (int i = 1; i <= 4; i++) begin
      drive_ph(1); cyc();
      chk("R1", "fwd cnt", cnt, i);
      chk("R2", "fwd dir", dir, 1);
    end
    for (int i = 3; i >= 0; i--) begin
      drive_ph(0); cyc();
      chk("R1", "rev cnt", cnt, i);
      chk("R1", "rev dir", dir, 0);
    end
  endtask

  task automatic t_bound_wrap();
    max_cnt = 16'd3; cyc();
    drive_ph(0); cyc();
    chk("R4", "down wrap", cnt, 3);
    drive_ph(1); cyc();
    chk("R4", "up wrap", cnt, 0);
    max_cnt = 16'd100;
  endtask

  task automatic t_x2();
    mode = 3'b101; cyc();
    drive_ph(1); cyc(); chk("R3", "A edge", cnt, 1);
    drive_ph(1); cyc(); chk("R3", "B edge ignored", cnt, 1);
    drive_ph(1); cyc(); chk("R3", "A edge 2", cnt, 2);
    drive_ph(1); cyc(); chk("R3", "B edge 2 ignored", cnt, 2);
  endtask

  task automatic t_off();
    mode = 3'b000; cyc();
    for (int i = 0; i < 4; i++) begin
      drive_ph(1); cyc();
      chk("R11", "off hold", cnt, 2);
    end
    idx = 1'b1; cyc();
    chk("R11", "off no idx irq", idx_irq, 0);
    idx = 1'b0; cyc();
  endtask

  task automatic t_err_up();
    mode = 3'b110; max_cnt = 16'd5; pos_res = 1'b0; cyc();
    for (int i = 3; i <= 5; i++) begin
      drive_ph(1); cyc();
      chk("R5", "no err yet", err_flag, 0);
    end
    drive_ph(1); cyc();
    chk("R5", "cnt max+1", cnt, 6);
    chk("R5", "err flag", err_flag, 1);
    chk("R5", "err irq", err_irq, 1);
    drive_ph(1); cyc();
    chk("R7", "counts on", cnt, 7);
    chk("R7", "flag sticky", err_flag, 1);
    chk("R5", "irq one cycle", err_irq, 0);
    err_clr = 1'b1; cyc(); err_clr = 1'b0;
    chk("R7", "flag cleared", err_flag, 0);
  endtask

  task automatic t_idx_err_down();
    mode = 3'b000; drive_ph(0); cyc();
    mode = 3'b110; pos_res = 1'b1; match = 2'b00; cyc();
    chk("R9", "before idx", cnt, 7);
    idx = 1'b1; cyc();
    chk("R9", "idx clear", cnt, 0);
    chk("R8", "idx irq", idx_irq, 1);
    cyc();
    chk("R8", "idx irq one cycle", idx_irq, 0);
    idx = 1'b0;
    drive_ph(0); cyc();
    chk("R5", "down to ffff", cnt, 16'hFFFF);
    chk("R5", "down err", {err_flag, err_irq}, 2'b11);
    err_clr = 1'b1; cyc(); err_clr = 1'b0;
    drive_ph(1); cyc();
    chk("R7", "up wrap cnt", cnt, 0);
    chk("R7", "up wrap no err", {err_flag, err_irq}, 2'b00);
    irq_dis = 1'b1;
    drive_ph(0); cyc();
    chk("R6", "masked flag/irq", {err_flag, err_irq}, 2'b10);
    err_clr = 1'b1; irq_dis = 1'b0; cyc(); err_clr = 1'b0;
  endtask

  task automatic t_match_x4();
    match = 2'b11; idx = 1'b1; cyc();
    chk("R10", "4x mismatch keeps", cnt, 16'hFFFF);
    chk("R8", "irq on mismatch", idx_irq, 1);
    idx = 1'b0; cyc();
    match = 2'b10; pos_res = 1'b0; idx = 1'b1; cyc();
    chk("R9", "pos_res 0 keeps", cnt, 16'hFFFF);
    idx = 1'b0; cyc();
    pos_res = 1'b1; idx = 1'b1; cyc();
    chk("R10", "4x match clears", cnt, 0);
    idx = 1'b0; cyc();
  endtask

  task automatic t_match_x2();
    mode = 3'b100; drive_ph(0); cyc();
    chk("R3", "2x A edge down", cnt, 16'hFFFF);
    match = 2'b00; idx = 1'b1; cyc();
    chk("R10", "2x A level mismatch", cnt, 16'hFFFF);
    idx = 1'b0; cyc();
    match = 2'b11; idx = 1'b1; cyc();
    chk("R10", "2x B level match", cnt, 0);
    idx = 1'b0; cyc();
  endtask

  task automatic t_priority();
    mode = 3'b110; cyc();
    drive_ph(0); cyc();
    drive_ph(0); cyc();
    chk("R2", "pre cnt", cnt, 16'hFFFE);
    match = 2'b01; drive_ph(1); idx = 1'b1; cyc();
    chk("R9", "clear beats count", cnt, 0);
    idx = 1'b0; cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    @(negedge clk); rst_ni = 1'b1; cyc();
    t_fwd_rev_x4();
    t_bound_wrap();
    t_x2();
    t_off();
    t_err_up();
    t_idx_err_down();
    t_match_x4();
    t_match_x2();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule